// File: doc/BRIEF.md
# Gated Counter Preload Sequencer

This block loads a start value into one counter of a clock-gated counter bank. The bank only accepts a write to a count register while the global count enable is set and that counter's own enable bit is set; at any other time the write is silently lost. The sequencer turns one load request into the full bus conversation the bank needs. It saves the enable mask and clears it, parks the target counter on an event code that never fires, and opens the target counter and the global enable. It then writes the value, closes the bank again and puts back the saved event select and enable mask. The other counters end with their counts and enables untouched.

The block is a single register-bus master. A request carries an operation, a counter index and a 32-bit value. Busy is high while an operation runs, and a one-cycle done pulse marks its end. A batch mode amortises the cost of several loads. An open operation saves and quiesces the bank once, and each later load adds only the steps its new target needs. A commit or a cancel closes the bank and restores every parked counter in one pass. The global count enable is assumed clear on entry and is left clear on exit.

Top module: `cgp_preload_seq`

## Requirements
- R1: Under reset and after it, busy, done and bus_req are low.
- R2: The bank map is: global control at 0x00 (bit 0 = global count enable), enable mask at 0x01 (bit i enables counter i), event select i at 0x10+i (source field in bits 7:5, code field in bits 4:0), and count i at 0x20+i. A single load (op 0, no batch open) makes 11 accesses in this order: read mask, write mask 0, read event select i, write the no-event code 0x1F (source 0, code 0x1F), write mask with only bit i, write global enable 1, write count i. At the count write the target is enabled alone, the global enable is set and the target is parked. Afterwards count i holds the value.
- R3: After a single load, the accesses continue: write global enable 0, write mask 0, write event select i back, and write the saved mask. The enable mask and every event select then equal their values from before the request. Every other count is unchanged and the global enable is clear.
- R4: A bus access holds bus_req, bus_we, bus_addr and bus_wdata steady until a cycle with bus_ready high, which completes it. Read data is taken in that same cycle.
- R5: Busy rises in the cycle after a request is accepted and stays high until done. A request made while busy is ignored. bus_req is low whenever busy is low.
- R6: Done is a one-cycle pulse that follows the final access, and busy is low in the cycle after it.
- R7: Op 1 opens a batch in 2 accesses: read mask, then write mask 0. The counts are untouched.
- R8: A load in an open batch to a counter not yet loaded in the batch makes 5 accesses for the first such counter and 4 for each later one. The global enable write occurs only once. A repeat load to a counter already loaded makes only the count write.
- R9: Op 2 (commit) clears the global enable and the mask, writes back the saved event select of every counter loaded in the batch in ascending index order, and then restores the saved mask. This takes 3 plus the number of such counters accesses.
- R10: Op 3 (cancel) performs the same restore as a commit and ends the batch. The values already written stay in place.
- R11: Commit or cancel with no batch open, and open with a batch already open, complete with a done pulse and no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 load, 1 open batch, 2 commit, 3 cancel |
| req_idx | input | IW | Target counter index |
| req_value | input | DW | Value to load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus access pending |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bank register address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| bus_ready | input | 1 | Completes the pending access |

## Verification
The assertions assume that the bank raises bus_ready only while bus_req is high. They also assume that the global enable is clear whenever a new operation starts. The bench bank model holds ready for exactly one cycle after a random wait of zero to three cycles, and every operation sequence ends with the global enable written back to zero. Requests are pulsed for a single cycle, except in the directed case that fires a second request on purpose while the block is busy.

// File: rtl/cgp_pkg.sv
package cgp_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_OPEN   = 2'd1,
        OP_COMMIT = 2'd2,
        OP_CANCEL = 2'd3
    } cgp_op_e;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_SAVE_MASK = 4'd1,
        ST_QUIESCE   = 4'd2,
        ST_EV_READ   = 4'd3,
        ST_EV_PARK   = 4'd4,
        ST_EN_TGT    = 4'd5,
        ST_GLOB_ON   = 4'd6,
        ST_WR_COUNT  = 4'd7,
        ST_GLOB_OFF  = 4'd8,
        ST_EN_CLR    = 4'd9,
        ST_EV_REST   = 4'd10,
        ST_MASK_REST = 4'd11,
        ST_DONE      = 4'd12
    } cgp_state_e;

endpackage

// File: rtl/cgp_bus_eng.sv
module cgp_bus_eng #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          bus_ready,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          xfer_done
);

    typedef struct packed {
        logic          pend;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (e_q.pend && bus_ready) begin
            e_d.pend = 1'b0;
        end else if (!e_q.pend && start) begin
            e_d.pend  = 1'b1;
            e_d.we    = we;
            e_d.addr  = addr;
            e_d.wdata = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign bus_req   = e_q.pend;
    assign bus_we    = e_q.we;
    assign bus_addr  = e_q.addr;
    assign bus_wdata = e_q.wdata;
    assign xfer_done = e_q.pend && bus_ready;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R4

endmodule

// File: rtl/cgp_evsave.sv
module cgp_evsave #(
    parameter int NCNT = 8,
    parameter int EVW  = 8,
    localparam int IW  = $clog2(NCNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_en,
    input  logic [IW-1:0]   save_idx,
    input  logic [EVW-1:0]  save_ev,
    input  logic            clr_all,
    input  logic [IW-1:0]   rd_idx,
    output logic [EVW-1:0]  rd_ev,
    output logic [NCNT-1:0] touched
);

    logic [EVW-1:0]  ev_d  [NCNT];
    logic [EVW-1:0]  ev_q  [NCNT];
    logic [NCNT-1:0] tch_d, tch_q;

    always_comb begin
        ev_d  = ev_q;
        tch_d = tch_q;
        if (clr_all) begin
            tch_d = '0;
        end else if (save_en) begin
            ev_d[save_idx]  = save_ev;
            tch_d[save_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCNT; i++) ev_q[i] <= '0;
            tch_q <= '0;
        end else begin
            ev_q  <= ev_d;
            tch_q <= tch_d;
        end
    end

    assign rd_ev   = ev_q[rd_idx];
    assign touched = tch_q;

    AST_SAVE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |-> !tch_q[save_idx]); // R8

endmodule

// File: rtl/cgp_preload_seq.sv
module cgp_preload_seq
    import cgp_pkg::*;
#(
    parameter int          NCNT        = 8,
    parameter int          DW          = 32,
    parameter int          AW          = 8,
    parameter int          EVW         = 8,
    parameter logic [7:0]  GCTRL_ADDR  = 8'h00,
    parameter logic [7:0]  ENMASK_ADDR = 8'h01,
    parameter logic [7:0]  EVSEL_BASE  = 8'h10,
    parameter logic [7:0]  COUNT_BASE  = 8'h20,
    parameter logic [7:0]  NOEV_CODE   = 8'h1F,
    localparam int         IW          = $clog2(NCNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [IW-1:0] req_idx,
    input  logic [DW-1:0] req_value,
    output logic          busy,
    output logic          done,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready
);

    localparam logic [AW-1:0] A_GCTRL  = AW'(GCTRL_ADDR);
    localparam logic [AW-1:0] A_ENMASK = AW'(ENMASK_ADDR);
    localparam logic [AW-1:0] A_EVSEL  = AW'(EVSEL_BASE);
    localparam logic [AW-1:0] A_COUNT  = AW'(COUNT_BASE);
    localparam logic [IW-1:0] LAST_IDX = IW'(NCNT - 1);

    typedef struct packed {
        cgp_state_e      st;
        logic            issued;
        logic            single;
        logic            batch;
        logic            gon;
        logic [IW-1:0]   idx;
        logic [DW-1:0]   value;
        logic [NCNT-1:0] mask;
        logic [IW-1:0]   ptr;
    } seq_t;

    seq_t s_d, s_q;

    logic            cmd_bus, cmd_start, cmd_we;
    logic [AW-1:0]   cmd_addr;
    logic [DW-1:0]   cmd_wdata;
    logic            xfer_done;
    logic            save_en, clr_all;
    logic [EVW-1:0]  rest_ev;
    logic [NCNT-1:0] touched;
    cgp_op_e         op;
    logic            unused_rdata;

    assign op           = cgp_op_e'(req_op);
    assign unused_rdata = ^bus_rdata;

    function automatic logic [AW-1:0] reg_at(input logic [AW-1:0] base, input logic [IW-1:0] i);
        return base + AW'(i);
    endfunction

    cgp_evsave #(.NCNT(NCNT), .EVW(EVW)) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (save_en),
        .save_idx (s_q.idx),
        .save_ev  (bus_rdata[EVW-1:0]),
        .clr_all  (clr_all),
        .rd_idx   (s_q.ptr),
        .rd_ev    (rest_ev),
        .touched  (touched)
    );

    cgp_bus_eng #(.AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .we        (cmd_we),
        .addr      (cmd_addr),
        .wdata     (cmd_wdata),
        .bus_ready (bus_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .xfer_done (xfer_done)
    );

    always_comb begin
        s_d       = s_q;
        cmd_bus   = 1'b0;
        cmd_we    = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        save_en   = 1'b0;
        clr_all   = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.idx   = req_idx;
                    s_d.value = req_value;
                    unique case (op)
                        OP_LOAD: begin
                            if (s_q.batch) begin
                                s_d.single = 1'b0;
                                s_d.st     = touched[req_idx] ? ST_WR_COUNT : ST_EV_READ;
                            end else begin
                                s_d.single = 1'b1;
                                s_d.st     = ST_SAVE_MASK;
                            end
                        end
                        OP_OPEN: begin
                            s_d.single = 1'b0;
                            s_d.st     = s_q.batch ? ST_DONE : ST_SAVE_MASK;
                        end
                        OP_COMMIT, OP_CANCEL: begin
                            s_d.st = s_q.batch ? ST_GLOB_OFF : ST_DONE;
                        end
                        default: s_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_SAVE_MASK: begin
                cmd_bus  = 1'b1;
                cmd_addr = A_ENMASK;
                if (xfer_done) begin
                    s_d.mask = bus_rdata[NCNT-1:0];
                    s_d.st   = ST_QUIESCE;
                end
            end
            ST_QUIESCE: begin
                cmd_bus  = 1'b1;
                cmd_we   = 1'b1;
                cmd_addr = A_ENMASK;
                if (xfer_done) begin
                    if (s_q.single) begin
                        s_d.st = ST_EV_READ;
                    end else begin
                        s_d.batch = 1'b1;
                        s_d.st    = ST_DONE;
                    end
                end
            end
            ST_EV_READ: begin
                cmd_bus  = 1'b1;
                cmd_addr = reg_at(A_EVSEL, s_q.idx);
                if (xfer_done) begin
                    save_en = 1'b1;
                    s_d.st  = ST_EV_PARK;
                end
            end
            ST_EV_PARK: begin
                cmd_bus   = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = reg_at(A_EVSEL, s_q.idx);
                cmd_wdata = DW'(NOEV_CODE);
                if (xfer_done) s_d.st = ST_EN_TGT;
            end
            ST_EN_TGT: begin
                cmd_bus   = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = A_ENMASK;
                cmd_wdata = DW'(touched);
                if (xfer_done) s_d.st = s_q.gon ? ST_WR_COUNT : ST_GLOB_ON;
            end
            ST_GLOB_ON: begin
                cmd_bus   = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = A_GCTRL;
                cmd_wdata = DW'(1);
                if (xfer_done) begin
                    s_d.gon = 1'b1;
                    s_d.st  = ST_WR_COUNT;
                end
            end
            ST_WR_COUNT: begin
                cmd_bus   = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = reg_at(A_COUNT, s_q.idx);
                cmd_wdata = s_q.value;
                if (xfer_done) s_d.st = s_q.single ? ST_GLOB_OFF : ST_DONE;
            end
            ST_GLOB_OFF: begin
                cmd_bus  = 1'b1;
                cmd_we   = 1'b1;
                cmd_addr = A_GCTRL;
                if (xfer_done) begin
                    s_d.gon = 1'b0;
                    s_d.st  = ST_EN_CLR;
                end
            end
            ST_EN_CLR: begin
                cmd_bus  = 1'b1;
                cmd_we   = 1'b1;
                cmd_addr = A_ENMASK;
                if (xfer_done) begin
                    s_d.ptr = '0;
                    s_d.st  = ST_EV_REST;
                end
            end
            ST_EV_REST: begin
                if (touched[s_q.ptr]) begin
                    cmd_bus   = 1'b1;
                    cmd_we    = 1'b1;
                    cmd_addr  = reg_at(A_EVSEL, s_q.ptr);
                    cmd_wdata = DW'(rest_ev);
                end
                if (!touched[s_q.ptr] || xfer_done) begin
                    if (s_q.ptr == LAST_IDX) s_d.st = ST_MASK_REST;
                    else                     s_d.ptr = s_q.ptr + 1'b1;
                end
            end
            ST_MASK_REST: begin
                cmd_bus   = 1'b1;
                cmd_we    = 1'b1;
                cmd_addr  = A_ENMASK;
                cmd_wdata = DW'(s_q.mask);
                if (xfer_done) begin
                    clr_all    = 1'b1;
                    s_d.batch  = 1'b0;
                    s_d.single = 1'b0;
                    s_d.st     = ST_DONE;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase

        cmd_start = cmd_bus && !s_q.issued;
        if (cmd_start) s_d.issued = 1'b1;
        if (xfer_done) s_d.issued = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != ST_IDLE);
    assign done = (s_q.st == ST_DONE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_COUNT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr >= A_COUNT && bus_addr < A_COUNT + AW'(NCNT)) |-> s_q.gon); // R2
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R5

endmodule

// File: tb/sim_cgp_preload_seq.sv
`timescale 1ns/1ps
module sim_cgp_preload_seq;

    localparam int N = 8;
    localparam logic [7:0] NOEV = 8'h1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [2:0]  req_idx = '0;
    logic [31:0] req_value = '0;
    logic        busy, done, bus_req, bus_we, bus_ready;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #4 clk = ~clk;

    cgp_preload_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_value(req_value), .busy(busy), .done(done),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // bank model
    logic        m_g;
    logic [7:0]  m_en;
    logic [7:0]  m_ev  [N];
    logic [31:0] m_cnt [N];
    logic [7:0]  cw_en, cw_ev;
    logic        cw_g;
    logic        rdy;
    logic [31:0] rdata;
    int          wt;
    int          txn;

    assign bus_ready = rdy;
    assign bus_rdata = rdata;

    function automatic logic [31:0] bank_read(input logic [7:0] a);
        if (a == 8'h00) return {31'd0, m_g};
        if (a == 8'h01) return {24'd0, m_en};
        if (a >= 8'h10 && a < 8'h18) return {24'd0, m_ev[a[2:0]]};
        if (a >= 8'h20 && a < 8'h28) return m_cnt[a[2:0]];
        return 32'hDEAD_BEEF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0; wt <= 0; txn <= 0; rdata <= '0;
            m_g <= 1'b0; m_en <= 8'b1010_0110;
            cw_en <= '0; cw_ev <= '0; cw_g <= 1'b0;
            for (int i = 0; i < N; i++) begin
                m_ev[i]  <= {3'(i), 5'(i * 3)};
                m_cnt[i] <= 32'h1000 * i + 32'd7;
            end
        end else begin
            for (int i = 0; i < N; i++)
                if (m_g && m_en[i] && m_ev[i] != NOEV && ($urandom % 2 == 1))
                    m_cnt[i] <= m_cnt[i] + 32'd1;
            if (rdy) begin
                rdy <= 1'b0;
                txn <= txn + 1;
                wt  <= int'($urandom % 4);
                if (bus_we) begin
                    if (bus_addr == 8'h00) m_g <= bus_wdata[0];
                    else if (bus_addr == 8'h01) m_en <= bus_wdata[7:0];
                    else if (bus_addr >= 8'h10 && bus_addr < 8'h18) m_ev[bus_addr[2:0]] <= bus_wdata[7:0];
                    else if (bus_addr >= 8'h20 && bus_addr < 8'h28) begin
                        if (m_g && m_en[bus_addr[2:0]]) m_cnt[bus_addr[2:0]] <= bus_wdata;
                        cw_en <= m_en; cw_ev <= m_ev[bus_addr[2:0]]; cw_g <= m_g;
                    end
                end
            end else if (bus_req) begin
                if (wt == 0) begin
                    rdy   <= 1'b1;
                    rdata <= bank_read(bus_addr);
                end else wt <= wt - 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int exp_single_txn();
        return 7 + 4;
    endfunction

    function automatic int exp_load_txn(input bit seen, input bit first);
        if (seen) return 1;
        return first ? 5 : 4;
    endfunction

    function automatic int exp_close_txn(input logic [7:0] tch);
        return 3 + $countones(tch);
    endfunction

    task automatic do_op(input logic [1:0] op, input int idx, input logic [31:0] val,
                         input bit intr, output int ntx);
        int t0;
        int n;
        bit gap;
        t0 = txn;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_idx = 3'(idx); req_value = val;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; gap = 0;
        while (!done && n < 5000) begin
            if (!busy) gap = 1;
            if (intr && n == 3) begin
                req_valid = 1'b1; req_op = 2'd0; req_idx = 3'(idx + 1); req_value = 32'hBAD0_BAD0;
            end
            if (intr && n == 4) req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(done && !gap, "R5", "busy held until done", gap, 0);
        @(negedge clk);
        chk(!done && !busy, "R6", "done one cycle then idle", {done, busy}, 0);
        ntx = txn - t0;
    endtask

    logic [7:0]  s_en;
    logic [7:0]  s_ev  [N];
    logic [31:0] s_cnt [N];

    task automatic snap();
        s_en = m_en;
        for (int i = 0; i < N; i++) begin s_ev[i] = m_ev[i]; s_cnt[i] = m_cnt[i]; end
    endtask

    task automatic single_load(input int idx, input logic [31:0] val, input bit intr);
        int ntx;
        bit ok_ev, ok_cnt;
        snap();
        do_op(2'd0, idx, val, intr, ntx);
        chk(ntx == exp_single_txn(), "R2", "single access count", ntx, exp_single_txn());
        chk(m_cnt[idx] == val, "R2", "target count loaded", m_cnt[idx], val);
        chk(cw_en == (8'd1 << idx) && cw_g && cw_ev == NOEV, "R2", "bank state at count write",
            {cw_g, cw_en, cw_ev}, {1'b1, 8'd1 << idx, NOEV});
        ok_ev = 1; ok_cnt = 1;
        for (int i = 0; i < N; i++) begin
            if (m_ev[i] != s_ev[i]) ok_ev = 0;
            if (i != idx && m_cnt[i] != s_cnt[i]) ok_cnt = 0;
        end
        chk(m_en == s_en && !m_g, "R3", "mask restored, global clear", {m_g, m_en}, {1'b0, s_en});
        chk(ok_ev, "R3", "event selects restored", ok_ev, 1);
        chk(ok_cnt, "R3", "other counts kept", ok_cnt, 1);
    endtask

    task automatic batch(input bit cancel, input int nloads);
        int ntx;
        logic [7:0]  tch;
        logic [31:0] ev_v [N];
        bit ok_ev, ok_cnt, first;
        snap();
        tch = '0; first = 1;
        do_op(2'd1, 0, 0, 0, ntx);
        chk(ntx == 2, "R7", "open access count", ntx, 2);
        chk(m_en == 8'd0 && m_cnt[0] == s_cnt[0], "R7", "bank quiesced", m_en, 0);
        for (int k = 0; k < nloads; k++) begin
            int idx;
            logic [31:0] v;
            int e;
            idx = int'($urandom % 4) * 2;
            v = $urandom;
            e = exp_load_txn(tch[idx], first);
            do_op(2'd0, idx, v, 0, ntx);
            chk(ntx == e, "R8", "batch load access count", ntx, e);
            chk(m_cnt[idx] == v, "R8", "batch target loaded", m_cnt[idx], v);
            chk(m_ev[idx] == NOEV, "R8", "target parked during batch", m_ev[idx], NOEV);
            tch[idx] = 1'b1; ev_v[idx] = v; first = 0;
        end
        do_op(cancel ? 2'd3 : 2'd2, 0, 0, 0, ntx);
        chk(ntx == exp_close_txn(tch), cancel ? "R10" : "R9", "close access count", ntx, exp_close_txn(tch));
        ok_ev = 1; ok_cnt = 1;
        for (int i = 0; i < N; i++) begin
            if (m_ev[i] != s_ev[i]) ok_ev = 0;
            if (tch[i] ? (m_cnt[i] != ev_v[i]) : (m_cnt[i] != s_cnt[i])) ok_cnt = 0;
        end
        chk(m_en == s_en && !m_g, cancel ? "R10" : "R9", "mask restored", {m_g, m_en}, {1'b0, s_en});
        chk(ok_ev, cancel ? "R10" : "R9", "event selects restored", ok_ev, 1);
        chk(ok_cnt, cancel ? "R10" : "R9", "counts after close", ok_cnt, 1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ntx;
        logic [31:0] keep;
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req, "R1", "reset outputs", {busy, done, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R1", "idle after reset", {busy, done, bus_req}, 0);

        // R11 directed: close with no batch open
        do_op(2'd2, 0, 0, 0, ntx);
        chk(ntx == 0, "R11", "commit without batch", ntx, 0);
        do_op(2'd3, 0, 0, 0, ntx);
        chk(ntx == 0, "R11", "cancel without batch", ntx, 0);

        // R2 R3 directed corners: lowest and highest index
        single_load(0, 32'h8000_0000, 0);
        single_load(N - 1, 32'hFFFF_FFFF, 0);

        // R5: request during busy is ignored
        keep = m_cnt[4];
        single_load(3, 32'h1234_5678, 1);
        chk(m_cnt[4] == keep, "R5", "request while busy ignored", m_cnt[4], keep);

        // R11 directed: open twice
        do_op(2'd1, 0, 0, 0, ntx);
        do_op(2'd1, 0, 0, 0, ntx);
        chk(ntx == 0, "R11", "open while open", ntx, 0);
        do_op(2'd2, 0, 0, 0, ntx);
        chk(ntx == 3, "R9", "commit of empty batch", ntx, 3);

        for (int k = 0; k < 30; k++) single_load(int'($urandom % N), $urandom, 0);
        for (int k = 0; k < 6; k++) batch(k[0], 3 + int'($urandom % 4));

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule